// File: doc/BRIEF.md
# Display Serial Byte Receiver

This block takes the write-only serial link of a display controller and turns it into whole bytes in the system clock domain. The host drives an active-low select, a serial clock, a data line and a line that marks each byte as a command or as pixel data. The block samples all four through synchronisers and finds serial clock rising edges in the system domain. It shifts bits in most significant first. When the eighth bit arrives it issues one valid pulse that carries the byte and its command/data tag.

A transfer begins when select falls, and every byte begins at bit 7. Raising select, or pulling the asynchronous reset low, throws away any partial byte and re-arms the receiver, so the next accepted bit is again bit 7. The system clock must run at least four times faster than the serial clock. The command decoder, the pixel memory and the drivers sit downstream and are not part of this block.

Top module: `disp_ser_rx`

## Requirements
- R1: After reset is released, `byte_vld` is low, and a transfer started after reset with no prior clocks yields its first byte correctly aligned.
- R2: While `cs_n` is high, serial clock rising edges have no effect: no byte is produced however many edges occur.
- R3: Bits are taken on serial clock rising edges, first bit into `byte_out[7]`, last bit into `byte_out[0]`.
- R4: `byte_is_data` holds the level of `dc` at the eighth rising edge of the byte (1 = display data, 0 = command). The level of `dc` at the other seven edges is ignored.
- R5: While `cs_n` stays low, the rising edge after a byte's eighth bit is bit 7 of the next byte, with no gap needed.
- R6: Raising `cs_n` after one to seven bits discards them. After `cs_n` falls again, the next edge is bit 7.
- R7: Asserting `rst_n` low in mid-byte discards the partial byte and produces no valid pulse. If `cs_n` is low when reset is released, the next edge is bit 7.
- R8: `byte_vld` is high for exactly one system clock cycle per completed byte.
- R9: If `cs_n` rises together with the eighth serial clock edge, the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dc | input | 1 | Tag line: high = display data, low = command |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_out | output | 8 | Received byte |
| byte_is_data | output | 1 | Tag captured with the eighth bit |

## Verification
The final serial clock edge of a byte and the rising edge of select can reach the synchroniser outputs in the same system cycle. One case has to be settled: does the byte complete, or does the abort win? The bench raises `sclk` and `cs_n` in the same instant on the eighth bit and expects no valid pulse. It then expects the next transfer to deliver a byte aligned from bit 7. Since both lines pass through synchronisers of equal depth, the edge and the abort reach the logic in the same cycle. That makes the check deterministic.

// File: rtl/disp_ser_rx.sv
module disp_ser_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              dc,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_is_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] cs_sync, ck_sync, sd_sync, dc_sync;
  logic                   ck_q;
  logic [CNT_W-1:0]       cnt;
  logic [BYTE_W-2:0]      shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= '1;
      ck_sync <= '0;
      sd_sync <= '0;
      dc_sync <= '0;
      ck_q    <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk};
      sd_sync <= {sd_sync[SYNC_STAGES-2:0], sdin};
      dc_sync <= {dc_sync[SYNC_STAGES-2:0], dc};
      ck_q    <= ck_sync[SYNC_STAGES-1];
    end
  end

  wire cs_s = cs_sync[SYNC_STAGES-1];
  wire ck_s = ck_sync[SYNC_STAGES-1];
  wire sd_s = sd_sync[SYNC_STAGES-1];
  wire dc_s = dc_sync[SYNC_STAGES-1];
  wire take = ck_s & ~ck_q & ~cs_s;
  wire last = (cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      shreg        <= '0;
      byte_vld     <= 1'b0;
      byte_out     <= '0;
      byte_is_data <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_s) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= {shreg[BYTE_W-3:0], sd_s};
        cnt   <= last ? '0 : cnt + 1'b1;
        if (last) begin
          byte_vld     <= 1'b1;
          byte_out     <= {shreg, sd_s};
          byte_is_data <= dc_s;
        end
      end
    end
  end

  a_r8_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  a_r2_idle_holds_counter: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0) && !byte_vld);

  a_r5_rearm_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> cnt == '0);

  a_r4_tag_from_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_is_data == $past(dc_s));

  a_r3_lsb_from_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_out[0] == $past(sd_s));
endmodule

// File: tb/disp_ser_rx_tb.sv
module disp_ser_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, dc = 1'b0;
  logic byte_vld, byte_is_data;
  logic [7:0] byte_out;
  int total = 0, bad = 0;
  int vld_cnt = 0, dbl_cnt = 0;
  logic [7:0] got_byte;
  logic got_dc;
  logic vld_prev = 1'b0;
  bit done = 1'b0;

  disp_ser_rx u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .dc(dc), .byte_vld(byte_vld), .byte_out(byte_out), .byte_is_data(byte_is_data));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (byte_vld) begin
      vld_cnt  <= vld_cnt + 1;
      got_byte <= byte_out;
      got_dc   <= byte_is_data;
      if (vld_prev) dbl_cnt <= dbl_cnt + 1;
    end
    vld_prev <= byte_vld;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, input logic d);
    sdin = b; dc = d;
    waitc(4); sclk = 1'b1;
    waitc(4); sclk = 1'b0;
  endtask

  task automatic byte_send(input logic [7:0] b, input logic d);
    for (int i = 7; i >= 0; i--) bit_out(b[i], d);
  endtask

  task automatic settle();
    waitc(8);
  endtask

  task automatic t_reset();
    waitc(3);
    chk(byte_vld == 1'b0, "R1 vld low after reset", byte_vld, 0);
    chk(vld_cnt == 0, "R1 no strobe at reset", vld_cnt, 0);
  endtask

  task automatic t_idle();
    int c0 = vld_cnt;
    cs_n = 1'b1;
    for (int i = 0; i < 12; i++) bit_out(1'b1, 1'b1);
    settle();
    chk(vld_cnt == c0, "R2 edges ignored with select high", vld_cnt - c0, 0);
  endtask

  task automatic t_basic(input logic [7:0] b, input logic d);
    int c0 = vld_cnt;
    cs_n = 1'b0; waitc(4);
    byte_send(b, d);
    settle();
    cs_n = 1'b1; waitc(4);
    chk(vld_cnt == c0 + 1, "R3 one byte received", vld_cnt - c0, 1);
    chk(got_byte == b, "R3 msb-first byte", got_byte, b);
    chk(got_dc == d, "R4 tag", got_dc, d);
  endtask

  task automatic t_tag_last(input logic last_dc);
    int c0 = vld_cnt;
    cs_n = 1'b0; waitc(4);
    for (int i = 7; i >= 1; i--) bit_out(i[0], ~last_dc);
    bit_out(1'b1, last_dc);
    settle(); cs_n = 1'b1; waitc(4);
    chk(vld_cnt == c0 + 1, "R4 byte count", vld_cnt - c0, 1);
    chk(got_dc == last_dc, "R4 tag from eighth edge", got_dc, last_dc);
    chk(got_byte == 8'hAB, "R4 byte value", got_byte, 8'hAB);
  endtask

  task automatic t_burst();
    int c0 = vld_cnt;
    logic [7:0] seq [3] = '{8'h5A, 8'hC3, 8'h0F};
    logic       tg  [3] = '{1'b0, 1'b1, 1'b1};
    cs_n = 1'b0; waitc(4);
    for (int k = 0; k < 3; k++) begin
      byte_send(seq[k], tg[k]);
      waitc(2);
      chk(got_byte == seq[k], "R5 back-to-back byte", got_byte, seq[k]);
      chk(got_dc == tg[k], "R5 back-to-back tag", got_dc, tg[k]);
    end
    cs_n = 1'b1; waitc(4);
    chk(vld_cnt == c0 + 3, "R5 three bytes", vld_cnt - c0, 3);
    chk(dbl_cnt == 0, "R8 strobe single cycle", dbl_cnt, 0);
  endtask

  task automatic t_cs_abort();
    int c0 = vld_cnt;
    cs_n = 1'b0; waitc(4);
    for (int i = 0; i < 5; i++) bit_out(1'b1, 1'b1);
    cs_n = 1'b1; waitc(6);
    chk(vld_cnt == c0, "R6 partial byte dropped", vld_cnt - c0, 0);
    cs_n = 1'b0; waitc(4);
    byte_send(8'h36, 1'b0);
    settle(); cs_n = 1'b1; waitc(4);
    chk(vld_cnt == c0 + 1, "R6 one byte after abort", vld_cnt - c0, 1);
    chk(got_byte == 8'h36, "R6 realigned to bit 7", got_byte, 8'h36);
  endtask

  task automatic t_rst_abort();
    int c0 = vld_cnt;
    cs_n = 1'b0; waitc(4);
    for (int i = 0; i < 6; i++) bit_out(1'b0, 1'b0);
    rst_n = 1'b0; waitc(3);
    chk(vld_cnt == c0, "R7 no strobe from reset abort", vld_cnt - c0, 0);
    rst_n = 1'b1; waitc(6);
    byte_send(8'h9E, 1'b1);
    settle(); cs_n = 1'b1; waitc(4);
    chk(vld_cnt == c0 + 1, "R7 one byte after reset", vld_cnt - c0, 1);
    chk(got_byte == 8'h9E, "R7 bit 7 first after reset", got_byte, 8'h9E);
    chk(got_dc == 1'b1, "R7 tag after reset", got_dc, 1);
  endtask

  task automatic t_collide();
    int c0 = vld_cnt;
    cs_n = 1'b0; waitc(4);
    for (int i = 0; i < 7; i++) bit_out(1'b1, 1'b1);
    sdin = 1'b1; waitc(4);
    sclk = 1'b1; cs_n = 1'b1;
    waitc(4); sclk = 1'b0; waitc(6);
    chk(vld_cnt == c0, "R9 abort wins over eighth edge", vld_cnt - c0, 0);
    cs_n = 1'b0; waitc(4);
    byte_send(8'h41, 1'b0);
    settle(); cs_n = 1'b1; waitc(4);
    chk(got_byte == 8'h41, "R9 clean byte after collision", got_byte, 8'h41);
    chk(vld_cnt == c0 + 1, "R9 one byte after collision", vld_cnt - c0, 1);
  endtask

  initial begin
    waitc(4); rst_n = 1'b1;
    t_reset();
    t_idle();
    t_basic(8'hA5, 1'b1);
    t_basic(8'h01, 1'b0);
    t_basic(8'h80, 1'b1);
    t_tag_last(1'b1);
    t_tag_last(1'b0);
    t_burst();
    t_cs_abort();
    t_rst_abort();
    t_collide();
    chk(dbl_cnt == 0, "R8 no stretched strobe overall", dbl_cnt, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule